// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a 45-bit physical address. It walks a radix page table with three levels that lives in ordinary memory. The walk starts from a root page number supplied by the caller. At each level the block reads one 8-byte entry through a single read port that uses a request/response handshake. Each valid entry gives the page number of the next table. The entry read at the last level gives the page number of the translated page.

After the third entry has been read, the block joins that page number with the untranslated low bits of the virtual address. It reports the result with a one-cycle completion pulse. If any entry it reads is marked invalid, the walk stops at once. The block then raises a one-cycle fault pulse and reports the level that failed. It is meant to sit behind a translation cache and serve that cache's misses one at a time.

Top module: `ptw_walker`

## Requirements
- R1: The virtual address is decoded as follows. The bits below bit 13 are the page offset. Bits 22:13 index the third-level table, bits 32:23 the second-level table and bits 42:33 the first-level table. Bits 63:43 are not used.
- R2: The read address for a level is the current table page number times 8192, plus the level's index times 8. On the first level the current page number is `root_ppn`, captured when the request is accepted.
- R3: Reads are issued strictly in the order first, second, third level, with never more than one outstanding. After the first two levels, the next table page number is taken from entry bits 63:32.
- R4: Once the third entry has been returned valid, `done` pulses high for exactly one cycle, in the cycle after that response. In the same cycle `pa` equals the entry's bits 63:32 placed above the 13 offset bits of the request.
- R5: Entry bit 0 is the valid flag. An entry with bit 0 low ends the walk: no further reads are made and `done` stays low. Instead `fault` pulses for one cycle, in the cycle after that response. `fault_level` then holds 1, 2 or 3 for the first, second or third level.
- R6: `req_ready` is high only while no walk is in progress. A `req_valid` raised during a walk is ignored: it starts no reads and does not change the walk's result.
- R7: `busy` rises in the cycle after a request is accepted, which is also the cycle in which the first read is requested. It stays high until the cycle that carries the `done` or `fault` pulse, and is low in that cycle.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and `mem_req_addr` does not change.
- R9: Changing only bits 63:43 of the request address changes neither the reads issued nor the resulting `pa`.
- R10: During and right after reset, `busy`, `done`, `fault` and `mem_req_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | Block is idle and will take a request |
| req_va | input | 64 | Virtual address to translate |
| root_ppn | input | 32 | Page number of the first-level table |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: translation complete |
| pa | output | 45 | Translated physical address, valid with `done` |
| fault | output | 1 | One-cycle pulse: an invalid entry was found |
| fault_level | output | 2 | Level of the invalid entry (1..3), valid with `fault` |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 45 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is returned |
| mem_rsp_data | input | 64 | The 8-byte entry |

## Verification
The bench builds the walker with its default parameters: a 64-bit virtual address, three levels of 10-bit indices, a 13-bit offset and a 32-bit page number held in bits 63:32 of each 64-bit entry. These values let directed walks cover several cases. Indices all zero and all ones probe the edges of the address decoding and the entry-address arithmetic. A page number of all ones exercises the top of the 45-bit result. An invalid entry is placed at each of the three levels in turn. A memory model with adjustable acceptance stalls and response delay covers both back-to-back handshakes and a held request.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    PTW_IDLE  = 2'd0,
    PTW_ISSUE = 2'd1,
    PTW_WAIT  = 2'd2
  } ptw_state_e;

endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
  parameter int USED_W = 43,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 13,
  parameter int LEVELS = 3
) (
  input  logic [USED_W-1:0] va,
  output logic [IDX_W-1:0]  idx_o [LEVELS],
  output logic [OFF_W-1:0]  off_o
);

  assign off_o = va[OFF_W-1:0];

  // level 0 (first walked) takes the most significant index field
  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx_o[l] = va[OFF_W + (LEVELS-1-l)*IDX_W +: IDX_W];
  end

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int LIDX_W = 2,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic              pte_valid,
  output logic              req_ready,
  output logic              busy,
  output logic              mem_req_valid,
  output logic [LIDX_W-1:0] level,
  output logic              ev_accept,
  output logic              ev_step,
  output logic              ev_last,
  output logic              ev_fault,
  output logic              done,
  output logic              fault,
  output logic [LVL_W-1:0]  fault_level
);

  ptw_state_e state;
  logic       ev_issue;
  logic       rsp_here;
  logic       at_last;

  assign req_ready     = (state == PTW_IDLE);
  assign busy          = (state != PTW_IDLE);
  assign mem_req_valid = (state == PTW_ISSUE);

  assign ev_accept = req_ready && req_valid;
  assign ev_issue  = mem_req_valid && mem_req_ready;
  assign rsp_here  = (state == PTW_WAIT) && mem_rsp_valid;
  assign at_last   = (level == LIDX_W'(LEVELS-1));
  assign ev_fault  = rsp_here && !pte_valid;
  assign ev_last   = rsp_here && pte_valid && at_last;
  assign ev_step   = rsp_here && pte_valid && !at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= PTW_IDLE;
      level       <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_level <= '0;
    end else begin
      done  <= ev_last;
      fault <= ev_fault;
      unique case (state)
        PTW_IDLE: if (ev_accept) begin
          state <= PTW_ISSUE;
          level <= '0;
        end
        PTW_ISSUE: if (ev_issue) state <= PTW_WAIT;
        PTW_WAIT: begin
          if (ev_fault) begin
            state       <= PTW_IDLE;
            fault_level <= LVL_W'(level) + LVL_W'(1);
          end else if (ev_last) begin
            state <= PTW_IDLE;
          end else if (ev_step) begin
            state <= PTW_ISSUE;
            level <= level + LIDX_W'(1);
          end
        end
        default: state <= PTW_IDLE;
      endcase
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue |=> !mem_req_valid);  // R3
  AST_FAULT_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_level != '0) && (fault_level <= LVL_W'(LEVELS)));  // R5
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_accept));  // R6

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int VA_W       = 64,
  parameter int IDX_W      = 10,
  parameter int OFF_W      = 13,
  parameter int LEVELS     = 3,
  parameter int PPN_W      = 32,
  parameter int PTE_W      = 64,
  parameter int PPN_LSB    = 32,
  parameter int ENTRY_LOG2 = 3,
  parameter int FLVL_W     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  input  logic [PPN_W-1:0]   root_ppn,
  output logic               busy,
  output logic               done,
  output logic [PPN_W+OFF_W-1:0] pa,
  output logic               fault,
  output logic [FLVL_W-1:0]  fault_level,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PPN_W+OFF_W-1:0] mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_data
);

  localparam int PA_W   = PPN_W + OFF_W;
  localparam int USED_W = OFF_W + LEVELS*IDX_W;
  localparam int LIDX_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  // byte address of one entry inside a table page
  function automatic logic [PA_W-1:0] entry_addr(input logic [PPN_W-1:0] base,
                                                 input logic [IDX_W-1:0] idx);
    logic [PA_W-1:0] page_part;
    logic [PA_W-1:0] slot_part;
    page_part = {base, {OFF_W{1'b0}}};
    slot_part = PA_W'(idx) << ENTRY_LOG2;
    return page_part + slot_part;
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [OFF_W-1:0] off);
    return {ppn, off};
  endfunction

  logic [USED_W-1:0] va_q;
  logic [PPN_W-1:0]  base_q;
  logic [PA_W-1:0]   pa_q;
  logic [IDX_W-1:0]  idx   [LEVELS];
  logic [OFF_W-1:0]  off;
  logic [LIDX_W-1:0] level;
  logic              ev_accept, ev_step, ev_last, ev_fault;
  logic [PPN_W-1:0]  pte_ppn;
  logic              pte_valid;
  logic              unused_va_hi;
  logic              unused_pte_bits;

  assign pte_ppn   = mem_rsp_data[PPN_LSB +: PPN_W];
  assign pte_valid = mem_rsp_data[0];
  assign unused_va_hi    = ^req_va[VA_W-1:USED_W];
  assign unused_pte_bits = ^mem_rsp_data[PPN_LSB-1:1];

  ptw_va_split #(
    .USED_W (USED_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W),
    .LEVELS (LEVELS)
  ) u_split (
    .va    (va_q),
    .idx_o (idx),
    .off_o (off)
  );

  ptw_fsm #(
    .LEVELS (LEVELS),
    .LIDX_W (LIDX_W),
    .LVL_W  (FLVL_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .pte_valid     (pte_valid),
    .req_ready     (req_ready),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .level         (level),
    .ev_accept     (ev_accept),
    .ev_step       (ev_step),
    .ev_last       (ev_last),
    .ev_fault      (ev_fault),
    .done          (done),
    .fault         (fault),
    .fault_level   (fault_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
      pa_q   <= '0;
    end else begin
      if (ev_accept) begin
        va_q   <= req_va[USED_W-1:0];
        base_q <= root_ppn;
      end
      if (ev_step) base_q <= pte_ppn;
      if (ev_last) pa_q   <= join_pa(pte_ppn, off);
    end
  end

  assign mem_req_addr = entry_addr(base_q, idx[level]);
  assign pa           = pa_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));  // R8
  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[ENTRY_LOG2-1:0] == '0));  // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R4
  AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));  // R5
  AST_BUSY_ENDS_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || fault));  // R7
  AST_PULSE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> !busy);  // R7

endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [31:0] root_ppn = '0;
  logic        busy, done, fault;
  logic [44:0] pa;
  logic [1:0]  fault_level;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [44:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .root_ppn(root_ppn), .busy(busy), .done(done), .pa(pa),
    .fault(fault), .fault_level(fault_level), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // ---------------- memory model ----------------
  logic [63:0] pmem [longint];
  longint      rd_log [8];
  int          rd_cnt = 0;
  int          lat_n = 0;
  int          stall_n = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  initial begin
    bit          pend = 0;
    int          pend_cnt = 0;
    logic [63:0] pend_data = '0;
    int          wait_ctr = 0;
    bit          hold_chk = 0;
    longint      hold_addr = 0;
    forever begin
      @(posedge clk);
      begin
        bit     hs;
        bit     stl;
        longint a;
        hs  = mem_req_valid && mem_req_ready;
        stl = mem_req_valid && !mem_req_ready;
        a   = longint'(mem_req_addr);
        if (hold_chk && rst_n)
          chk(mem_req_valid && a == hold_addr, "R8", "held request address", a, hold_addr);
        hold_chk  = stl;
        hold_addr = a;
        if (stl) wait_ctr++;
        if (hs) begin
          wait_ctr = 0;
          if (rd_cnt < 8) rd_log[rd_cnt] = a;
          rd_cnt++;
          pend      = 1;
          pend_cnt  = lat_n;
          pend_data = pmem.exists(a) ? pmem[a] : 64'd0;
        end
      end
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (pend_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pend_data;
          pend = 0;
        end else pend_cnt--;
      end
      mem_req_ready = (wait_ctr >= stall_n);
    end
  end

  // ---------------- bench helpers ----------------
  function automatic longint idx_of(input logic [63:0] va, input int lvl);
    return longint'((va >> (13 + 10*(3-lvl))) & 64'h3FF);
  endfunction

  function automatic longint slot(input longint base, input longint idx);
    return base*8192 + idx*8;
  endfunction

  function automatic logic [63:0] mk_pte(input logic [31:0] ppn, input bit v);
    return {ppn, 31'd0, v};
  endfunction

  // build a three-level mapping; bad_lvl (1..3) gets an invalid entry, 0 none
  task automatic map(input logic [63:0] va, input logic [31:0] root,
                     input logic [31:0] t2, input logic [31:0] t3,
                     input logic [31:0] fin, input int bad_lvl);
    pmem.delete();
    pmem[slot(root, idx_of(va,1))] = mk_pte(t2,  bad_lvl != 1);
    pmem[slot(t2,   idx_of(va,2))] = mk_pte(t3,  bad_lvl != 2);
    pmem[slot(t3,   idx_of(va,3))] = mk_pte(fin, bad_lvl != 3);
  endtask

  // issue one request and follow it to its end pulse
  task automatic run(input logic [63:0] va, input logic [31:0] root, input bit poke,
                     output bit got_done, output bit got_fault,
                     output logic [44:0] got_pa, output logic [1:0] got_lvl);
    int  cyc = 0;
    bit  busy_ok = 1;
    @(negedge clk);
    rd_cnt = 0;
    chk(req_ready, "R6", "req_ready before request", req_ready, 1);
    req_valid = 1'b1; req_va = va; root_ppn = root;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && mem_req_valid, "R7", "busy and first read right after accept",
        {busy, mem_req_valid}, 2'b11);
    got_done = 0; got_fault = 0;
    while (!(done || fault) && cyc < 500) begin
      if (!busy) busy_ok = 0;
      if (poke && cyc < 3) begin
        req_valid = 1'b1; req_va = ~va; root_ppn = ~root;
        chk(!req_ready, "R6", "req_ready low during walk", req_ready, 0);
      end else req_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(busy_ok, "R7", "busy high through walk", busy_ok, 1);
    chk(cyc < 500, "R4", "walk ended", cyc, 0);
    got_done = done; got_fault = fault; got_pa = pa; got_lvl = fault_level;
    chk(!busy, "R7", "busy low in end-pulse cycle", busy, 0);
    @(negedge clk);
    chk(!done && !fault, "R4", "end pulse lasts one cycle", {done, fault}, 0);
  endtask

  task automatic t_walk(input logic [63:0] va, input logic [31:0] root,
                        input logic [31:0] t2, input logic [31:0] t3, input logic [31:0] fin,
                        input int lat, input int stl, input bit poke);
    bit d, f; logic [44:0] p; logic [1:0] lv;
    lat_n = lat; stall_n = stl;
    map(va, root, t2, t3, fin, 0);
    run(va, root, poke, d, f, p, lv);
    chk(d && !f, "R4", "done without fault", {d, f}, 2'b10);
    chk(p == {fin, va[12:0]}, "R4", "physical address", p, {fin, va[12:0]});
    chk(rd_cnt == 3, "R3", "three reads", rd_cnt, 3);
    chk(rd_log[0] == slot(root, idx_of(va,1)), "R1 R2", "level-1 address", rd_log[0], slot(root, idx_of(va,1)));
    chk(rd_log[1] == slot(t2, idx_of(va,2)), "R1 R3", "level-2 address", rd_log[1], slot(t2, idx_of(va,2)));
    chk(rd_log[2] == slot(t3, idx_of(va,3)), "R1 R3", "level-3 address", rd_log[2], slot(t3, idx_of(va,3)));
    if (poke) chk(rd_cnt == 3, "R6", "request during walk ignored", rd_cnt, 3);
  endtask

  task automatic t_fault(input int lvl);
    bit d, f; logic [44:0] p; logic [1:0] lv;
    logic [63:0] va = 64'h0000_0123_4567_89AB;
    lat_n = 1; stall_n = 0;
    map(va, 32'h100, 32'h200, 32'h300, 32'h400, lvl);
    run(va, 32'h100, 0, d, f, p, lv);
    chk(f && !d, "R5", "fault without done", {f, d}, 2'b10);
    chk(lv == 2'(lvl), "R5", "fault level", lv, lvl);
    repeat (4) @(negedge clk);
    chk(rd_cnt == lvl, "R5", "no reads after invalid entry", rd_cnt, lvl);
  endtask

  task automatic t_upper_ignored;
    bit d, f; logic [44:0] p0, p1; logic [1:0] lv;
    longint a0;
    logic [63:0] va = 64'h0000_05A5_A5A5_1234;
    lat_n = 0; stall_n = 1;
    map(va, 32'h77, 32'h88, 32'h99, 32'hABCD, 0);
    run(va, 32'h77, 0, d, f, p0, lv);
    a0 = rd_log[2];
    run(va | 64'hFFFF_F800_0000_0000, 32'h77, 0, d, f, p1, lv);
    chk(d && p1 == p0, "R9", "upper bits ignored: pa", p1, p0);
    chk(rd_log[2] == a0 && rd_cnt == 3, "R9", "upper bits ignored: reads", rd_log[2], a0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !mem_req_valid && req_ready, "R10", "state in reset",
        {busy, done, fault, mem_req_valid, req_ready}, 5'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fault && !mem_req_valid && req_ready, "R10", "state after reset",
        {busy, done, fault, mem_req_valid, req_ready}, 5'b00001);

    t_walk(64'h0000_0123_4567_89AB, 32'h10, 32'h20, 32'h30, 32'h1234_5678, 0, 0, 0);
    t_walk(64'h0,                   32'h0,  32'h1,  32'h2,  32'hFFFF_FFFF, 2, 0, 0);
    t_walk(64'h0000_07FF_FFFF_FFFF, 32'hFFFF_FFF0, 32'h5, 32'h6, 32'h8000_0001, 3, 2, 0);
    t_walk(64'h0000_0400_8020_1FFF, 32'h4000, 32'h5000, 32'h6000, 32'h0000_00C3, 1, 3, 1);
    t_fault(1);
    t_fault(2);
    t_fault(3);
    t_upper_ignored();

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule